// File: doc/BRIEF.md
# PWM Pulse Edge Calculator

This block converts a duty request and a pulse-center request, both scaled so that 65536 stands for one whole period, into the pair of compare values that place one PWM pulse inside a counter period. The compare counter and the output pin are separate blocks. This one supplies the numbers they compare against.

The period count is not an input. The block derives it from a source clock rate, a power-of-two prescale shift and a target output frequency, and rounds the result to the nearest count. A single start strobe captures all inputs. A restoring divider then works one quotient bit per cycle. In the cycle after the division finishes, the block registers the period count, the rising-edge value and the falling-edge value, and it raises done for one cycle.

The center is moved where needed so that the pulse never crosses either end of the period. A duty of 65536 or more gives a pulse that covers the whole period.

Top module: `pwm_edge_calc`

## Requirements
- R1: period_o equals ((src_clk_i >> presc_i) + (F-1)/2) / F with integer division. F is freq_i, except that a freq_i of 0 is treated as 1.
- R2: When duty_i is 65536 or more (duty_i bit 16 set), rise_o is 0 and fall_o equals period_o.
- R3: Let half be duty_i/2, for duty below 65536. When center_i + half is 65536 or more, the center used is 65535 - half.
- R4: For duty below 65536, when center_i is less than half, the center used is half.
- R5: For duty below 65536, fall_o - rise_o (modulo 2^32) equals (period_o * duty_i) >> 16.
- R6: For duty below 65536, rise_o equals ((period_o * C) >> 16) - (W >> 1), modulo 2^32. C is the center used and W is the width from R5.
- R7: done_o is high for exactly one cycle. It is high in the cycle that follows the 34th rising clock edge after the edge that samples start_i. busy_o is high from the cycle after that sampling edge up to that point.
- R8: A start_i pulse that arrives while busy_o is high is ignored, together with any input values present at that time. The results that follow depend only on the inputs captured by the accepted start.
- R9: After reset, period_o, rise_o and fall_o are 0, and busy_o and done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe; inputs are captured on it while idle |
| src_clk_i | input | 32 | Source clock rate in Hz |
| presc_i | input | 4 | Prescale shift amount |
| freq_i | input | 32 | Target PWM frequency in Hz |
| duty_i | input | 17 | Duty, 65536 = always on |
| center_i | input | 16 | Pulse-center position, 65536 = one period |
| period_o | output | 32 | Derived period count |
| rise_o | output | 32 | Rising-edge compare value |
| fall_o | output | 32 | Falling-edge compare value |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle pulse when the outputs are valid |

## Verification
All three results appear together, 34 clock edges after the edge that samples start. The reason is that the divider needs 33 iterations and the output registers need one more edge. The bench drives start on a falling edge and counts rising edges until done appears. It checks that the count is exactly 34, compares period, rise and fall in that same cycle, and confirms one edge later that done has dropped. For the ignored-start case, a second strobe is injected a few edges into a run. The results of the first request must still appear at the same cycle.

// File: rtl/pec_pkg.sv
package pec_pkg;
  localparam int DUTY_W = 17;
  localparam int CTR_W  = 16;
  localparam int SCALE_SH = 16;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_DIV  = 1'b1
  } pec_state_e;
endpackage

// File: rtl/pec_period_div.sv
module pec_period_div #(
  parameter int CW = 32,
  localparam int NB = CW + 1,
  localparam int CNTW = $clog2(NB + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [NB-1:0] num_i,
  input  logic [CW-1:0] den_i,
  output logic          valid_o,
  output logic [NB-1:0] quot_o
);
  logic [NB-1:0]   q_q, q_n;
  logic [CW-1:0]   rem_q, rem_n;
  logic [CW-1:0]   den_q, den_n;
  logic [CNTW-1:0] cnt_q, cnt_n;
  logic            valid_q, valid_n;

  logic [CW:0] shifted;
  logic [CW:0] diff;
  logic        ge;

  always_comb begin
    shifted = {rem_q, q_q[NB-1]};
    ge      = shifted >= {1'b0, den_q};
    diff    = shifted - {1'b0, den_q};
  end

  always_comb begin
    q_n     = q_q;
    rem_n   = rem_q;
    den_n   = den_q;
    cnt_n   = cnt_q;
    valid_n = 1'b0;
    if (load_i) begin
      q_n   = num_i;
      rem_n = '0;
      den_n = den_i;
      cnt_n = CNTW'(NB);
    end else if (cnt_q != '0) begin
      q_n     = {q_q[NB-2:0], ge};
      rem_n   = ge ? CW'(diff) : CW'(shifted);
      cnt_n   = cnt_q - 1'b1;
      valid_n = (cnt_q == CNTW'(1));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q     <= '0;
      rem_q   <= '0;
      den_q   <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      q_q     <= q_n;
      rem_q   <= rem_n;
      den_q   <= den_n;
      cnt_q   <= cnt_n;
      valid_q <= valid_n;
    end
  end

  assign valid_o = valid_q;
  assign quot_o  = q_q;

  // R1: remainder of a finished division is below the divisor
  a_r1_rem_below_den: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (rem_q < den_q));
  // R1: the rounded quotient always fits in the period width
  a_r1_quot_fits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> !q_q[NB-1]);
endmodule

// File: rtl/pec_center_clamp.sv
module pec_center_clamp
  import pec_pkg::*;
(
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [CTR_W-1:0]  center_i,
  output logic [CTR_W-1:0]  center_o
);
  logic [CTR_W-1:0] half;
  logic [CTR_W:0]   reach;

  always_comb begin
    half  = duty_i[DUTY_W-1:1];
    reach = {1'b0, center_i} + {1'b0, half};
    if (reach[CTR_W]) begin
      center_o = {CTR_W{1'b1}} - half;
    end else if (center_i < half) begin
      center_o = half;
    end else begin
      center_o = center_i;
    end
  end
endmodule

// File: rtl/pec_edge_math.sv
module pec_edge_math
  import pec_pkg::*;
#(
  parameter int CW = 32,
  localparam int PDW = CW + DUTY_W,
  localparam int PCW = CW + CTR_W
) (
  input  logic [CW-1:0]     period_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [CTR_W-1:0]  center_i,
  output logic [CW-1:0]     rise_o,
  output logic [CW-1:0]     fall_o
);
  logic [PDW-1:0] prod_w;
  logic [PCW-1:0] prod_c;
  logic [CW-1:0]  width;
  logic [CW-1:0]  mid;
  logic [CW-1:0]  lead;

  always_comb begin
    prod_w = {{DUTY_W{1'b0}}, period_i} * {{CW{1'b0}}, duty_i};
    prod_c = {{CTR_W{1'b0}}, period_i} * {{CW{1'b0}}, center_i};
    width  = CW'(prod_w >> SCALE_SH);
    mid    = CW'(prod_c >> SCALE_SH);
    lead   = mid - (width >> 1);
    if (duty_i[DUTY_W-1]) begin
      rise_o = '0;
      fall_o = period_i;
    end else begin
      rise_o = lead;
      fall_o = lead + width;
    end
  end
endmodule

// File: rtl/pwm_edge_calc.sv
module pwm_edge_calc
  import pec_pkg::*;
#(
  parameter int CW  = 32,
  parameter int PSW = 4,
  localparam int NB = CW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CW-1:0]     src_clk_i,
  input  logic [PSW-1:0]    presc_i,
  input  logic [CW-1:0]     freq_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [CTR_W-1:0]  center_i,
  output logic [CW-1:0]     period_o,
  output logic [CW-1:0]     rise_o,
  output logic [CW-1:0]     fall_o,
  output logic              busy_o,
  output logic              done_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  pec_state_e state_q, state_n;
  logic              cap_en, out_en;
  logic [DUTY_W-1:0] duty_q;
  logic [CTR_W-1:0]  center_q;
  logic [CW-1:0]     freq_eff;
  logic [NB-1:0]     num;
  logic              div_valid;
  logic [NB-1:0]     div_quot;
  logic [CW-1:0]     period_w;
  logic [CTR_W-1:0]  center_used;
  logic [CW-1:0]     rise_w, fall_w;
  logic [CW-1:0]     period_q, rise_q, fall_q;
  logic              done_q, done_n;

  always_comb begin
    freq_eff = (freq_i == '0) ? CW'(1) : freq_i;
    num      = {1'b0, src_clk_i >> presc_i} + {1'b0, (freq_eff - 1'b1) >> 1};
    cap_en   = start_i && (state_q == ST_IDLE);
    out_en   = (state_q == ST_DIV) && div_valid;
    period_w = CW'(div_quot);
  end

  always_comb begin
    state_n = state_q;
    done_n  = 1'b0;
    case (state_q)
      ST_IDLE: if (cap_en) state_n = ST_DIV;
      ST_DIV: if (out_en) begin
        state_n = ST_IDLE;
        done_n  = 1'b1;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  pec_period_div #(.CW(CW)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .load_i (cap_en),
    .num_i  (num),
    .den_i  (freq_eff),
    .valid_o(div_valid),
    .quot_o (div_quot)
  );

  pec_center_clamp u_clamp (
    .duty_i  (duty_q),
    .center_i(center_q),
    .center_o(center_used)
  );

  // R3 R4: for partial duty the used center keeps the pulse inside the period
  a_r3_center_in_range: assert property (@(posedge clk_i) disable iff (!rst_n)
    (out_en && !duty_q[DUTY_W-1]) |->
      (({1'b0, center_used} + {1'b0, duty_q[DUTY_W-1:1]}) < 17'h10000)
      && (center_used >= duty_q[DUTY_W-1:1]));

  pec_edge_math #(.CW(CW)) u_edges (
    .period_i(period_w),
    .duty_i  (duty_q),
    .center_i(center_used),
    .rise_o  (rise_w),
    .fall_o  (fall_w)
  );

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      duty_q   <= '0;
      center_q <= '0;
      period_q <= '0;
      rise_q   <= '0;
      fall_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      done_q  <= done_n;
      if (cap_en) begin
        duty_q   <= duty_i;
        center_q <= center_i;
      end
      if (out_en) begin
        period_q <= period_w;
        rise_q   <= rise_w;
        fall_q   <= fall_w;
      end
    end
  end

  assign period_o = period_q;
  assign rise_o   = rise_q;
  assign fall_o   = fall_q;
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;

  // R7: done lasts a single cycle
  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |=> !done_o);
  // R7: done only follows a busy period
  a_r7_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |-> ($past(busy_o) && !busy_o));
  // R8: a strobe during a run leaves the captured request untouched
  a_r8_hold_request: assert property (@(posedge clk_i) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(duty_q) && $stable(center_q)));
  // R2: full duty spans the whole period
  a_r2_full_span: assert property (@(posedge clk_i) disable iff (!rst_n)
    (done_o && duty_q[DUTY_W-1]) |-> (rise_o == '0 && fall_o == period_o));
endmodule

// File: tb/pwm_edge_calc_tb.sv
module pwm_edge_calc_tb;
  localparam int CW = 32;
  localparam int LAT = CW + 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] src_clk, freq;
  logic [3:0]  presc;
  logic [16:0] duty;
  logic [15:0] center;
  logic [31:0] period, rise, fall;
  logic        busy, done;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pwm_edge_calc u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .src_clk_i(src_clk), .presc_i(presc), .freq_i(freq),
    .duty_i(duty), .center_i(center),
    .period_o(period), .rise_o(rise), .fall_o(fall),
    .busy_o(busy), .done_o(done)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
  end

  task automatic chk(input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected values from the requirements; clamp code: 0 none, 3 high, 4 low, 2 full
  function automatic void model(input logic [31:0] s, input logic [3:0] p,
      input logic [31:0] f, input logic [16:0] d, input logic [15:0] c,
      output logic [31:0] per, output logic [31:0] ri, output logic [31:0] fa,
      output int code);
    longint unsigned ff, num, h, cc, wd, cs, mask;
    mask = 64'hFFFF_FFFF;
    ff   = (f == 0) ? 1 : longint'(f);
    num  = (longint'(s) >> p) + (ff - 1) / 2;
    per  = 32'(num / ff);
    code = 0;
    if (d >= 17'h10000) begin
      ri = 0; fa = per; code = 2;
    end else begin
      h  = d / 2;
      cc = c;
      if (cc + h >= 65536) begin cc = 65535 - h; code = 3; end
      else if (cc < h) begin cc = h; code = 4; end
      wd = (longint'(per) * d) >> 16;
      cs = (longint'(per) * cc) >> 16;
      ri = 32'(((cs - wd / 2) & mask));
      fa = 32'(((longint'(ri) + wd) & mask));
    end
  endfunction

  task automatic run(input logic [31:0] s, input logic [3:0] p, input logic [31:0] f,
                     input logic [16:0] d, input logic [15:0] c, input bit inject);
    logic [31:0] ep, er, ef;
    int code, n;
    string rtag;
    model(s, p, f, d, c, ep, er, ef, code);
    @(negedge clk);
    src_clk = s; presc = p; freq = f; duty = d; center = c; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < LAT + 5) begin
      if (inject && n == 4) begin
        src_clk = ~s; presc = p + 4'd1; freq = f + 32'd7;
        duty = d ^ 17'h0F0F0; center = ~c; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
      n++;
      if (n == 1) chk("R7", "busy during run", busy, 1);
    end
    start = 1'b0;
    chk("R7", "done latency", n, LAT);
    chk(inject ? "R8" : "R1", "period", period, ep);
    rtag = (code == 3) ? "R3" : (code == 4) ? "R4" : (code == 2) ? "R2" : "R6";
    chk(rtag, "rise", rise, er);
    chk(code == 2 ? "R2" : "R5", "fall", fall, ef);
    chk("R5", "width", 32'(fall - rise), 32'(ef - er));
    @(posedge clk);
    @(negedge clk);
    chk("R7", "done single cycle", done, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0;
    src_clk = '0; presc = '0; freq = '0; duty = '0; center = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9", "reset period", period, 0);
    chk("R9", "reset rise", rise, 0);
    chk("R9", "reset fall", fall, 0);
    chk("R9", "reset busy", busy, 0);
    chk("R9", "reset done", done, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // directed corners
    run(32'd150_000_000, 4'd0, 32'd1000, 17'd32768, 16'd32768, 1'b0);
    run(32'd150_000_000, 4'd2, 32'd20000, 17'h10000, 16'd100, 1'b0);   // R2 full
    run(32'd150_000_000, 4'd0, 32'd3000, 17'h1FFFF, 16'd0, 1'b0);      // R2 above full
    run(32'd100_000_000, 4'd1, 32'd5000, 17'd40000, 16'd65000, 1'b0);  // R3 high clamp
    run(32'd100_000_000, 4'd1, 32'd5000, 17'd40000, 16'd10, 1'b0);     // R4 low clamp
    run(32'd100_000_000, 4'd0, 32'd7000, 17'd0, 16'd30000, 1'b0);      // zero duty
    run(32'd100_000_000, 4'd0, 32'd7000, 17'd65535, 16'd32767, 1'b0);  // R3 near full
    run(32'hFFFF_FFFF, 4'd0, 32'd1, 17'd1000, 16'd500, 1'b0);          // R1 largest count
    run(32'd12345, 4'd3, 32'd0, 17'd20000, 16'd40000, 1'b0);           // R1 zero freq
    run(32'd99, 4'd15, 32'd3, 17'd12345, 16'd54321, 1'b0);             // R1 tiny count
    run(32'd48_000_000, 4'd2, 32'd25000, 17'd30000, 16'd20000, 1'b1);  // R8 ignored start

    for (int i = 0; i < 40; i++) begin
      run($urandom, 4'($urandom % 16), 32'(1 + $urandom % 200000),
          17'($urandom % 70000), 16'($urandom), (i % 8) == 3);
    end
    summary();
  end
endmodule